// File: doc/BRIEF.md
# Branch Condition and Counter Unit

This unit decides whether a conditional branch is taken. Each request carries a 5-bit branch-options field, one condition bit that the core has already selected, and a branch kind: relative, via the link register, or via the count register. The options field selects the tests to apply. The branch can test the condition bit alone, decrement the internal 32-bit count register and test it alone, do both, or branch unconditionally. The unit also passes on a static taken/not-taken hint.

The unit holds the count register. It can be loaded through a dedicated port and is visible on `ctr_o`. The taken, hint and error results are combinational from the current request and the current counter value. When a valid request asks for a decrement, the counter is updated on the next rising clock edge. If an options field is malformed, the request is marked invalid and a numeric error code is given. A branch via the count register that asks for a decrement is also invalid. An invalid request is never taken and does not change the counter. Target address generation and link register handling are outside this block.

Top module: `branch_resolve_unit`

## Requirements
- R1: While `rst_ni` is low, and after its release until the first load, `ctr_o` is 0. With no request, `taken_o`, `hint_o` and `invalid_o` are 0 and `err_code_o` is 0.
- R2: When `ctr_load_i` is high, `ctr_load_val_i` is written to the counter on the next rising edge. This overrides any decrement requested in the same cycle.
- R3: Let `bo_i[4:0]` = {a,b,c,d,e}, with a = bo_i[4]. If a=0 and c=1, the branch is taken when `cond_i` equals b, and the counter is not changed.
- R4: If a=0 and c=0, a valid request decrements the counter on the next edge. The branch is taken only when `cond_i` equals b and the counter test passes.
- R5: The counter test uses the current counter minus one, with 0 wrapping to 0xFFFFFFFF. It passes when that value is nonzero if d=0, and when it is zero if d=1.
- R6: If a=1 and c=0, a valid request decrements the counter. The branch is taken on the counter test alone, and `cond_i` has no effect.
- R7: If a=1 and c=1, a valid request is taken and `hint_o` is 0.
- R8: A reserved bit that is nonzero makes the request invalid with `err_code_o` = 150. The reserved bits are d when a=0 and c=1; b when a=1; and d and e when a=1 and c=1. This error takes priority over R9.
- R9: When `kind_i` = 2 (via count register) and c=0, the request is invalid with `err_code_o` = 163. Kinds 0 (relative), 1 (link) and 3 (treated as relative) carry no such restriction.
- R10: An invalid request gives `taken_o` = 0 and `hint_o` = 0, and leaves the counter unchanged.
- R11: For a valid request that is not the unconditional form, `hint_o` equals e. The value of e never changes `taken_o`.
- R12: With `req_i` low, all outputs except `ctr_o` are 0 and the counter changes only by a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctr_load_i | input | 1 | Load the count register |
| ctr_load_val_i | input | 32 | Value to load |
| req_i | input | 1 | Branch request strobe |
| bo_i | input | 5 | Branch-options field {a,b,c,d,e} |
| cond_i | input | 1 | Selected condition bit |
| kind_i | input | 2 | Branch kind: 0 relative, 1 link, 2 count register, 3 as relative |
| taken_o | output | 1 | Branch taken |
| hint_o | output | 1 | Prediction hint |
| invalid_o | output | 1 | Request has an invalid form |
| err_code_o | output | 8 | 0, or 150 / 163 for invalid forms |
| ctr_o | output | 32 | Current count register |

## Verification
The assertions assume that `req_i`, `bo_i`, `cond_i`, `kind_i` and the load inputs are stable and known around each rising edge. They also assume that reset is asserted before the first request. The stimulus meets this by changing all inputs only on the falling edge and by holding reset low for several cycles at the start. Load values are drawn mostly from 0 to 3, with 0xFFFFFFFF added, so that the zero test, the nonzero test and the wrap from 0 all occur often.

// File: rtl/bru_pkg.sv
package bru_pkg;
  localparam int unsigned BO_W = 5;

  typedef enum logic [1:0] {
    KIND_REL = 2'd0,
    KIND_LNK = 2'd1,
    KIND_CTR = 2'd2,
    KIND_RSV = 2'd3
  } br_kind_e;

  typedef struct packed {
    logic use_cond;
    logic cond_sense;
    logic use_ctr;
    logic ctr_zero;
    logic always_tk;
    logic hint;
  } bo_fields_t;
endpackage

// File: rtl/bru_bo_decode.sv
module bru_bo_decode
  import bru_pkg::*;
#(
  parameter int unsigned ERR_W   = 8,
  parameter int unsigned ERR_Z   = 150,
  parameter int unsigned ERR_CTR = 163
) (
  input  logic [BO_W-1:0]  bo_i,
  input  logic [1:0]       kind_i,
  output bo_fields_t       fld_o,
  output logic             invalid_o,
  output logic [ERR_W-1:0] err_code_o
);
  logic a, b, c, d, e;
  logic z_bad, ctr_bad;

  assign {a, b, c, d, e} = bo_i;

  always_comb begin
    fld_o.use_cond   = ~a;
    fld_o.cond_sense = b;
    fld_o.use_ctr    = ~c;
    fld_o.ctr_zero   = d;
    fld_o.always_tk  = a & c;
    fld_o.hint       = (a & c) ? 1'b0 : e;
  end

  // reserved positions per form
  assign z_bad   = (~a & c & d) | (a & b) | (a & c & (d | e));
  assign ctr_bad = (br_kind_e'(kind_i) == KIND_CTR) & ~c;

  always_comb begin
    invalid_o  = z_bad | ctr_bad;
    err_code_o = '0;
    if (z_bad)        err_code_o = ERR_W'(ERR_Z);
    else if (ctr_bad) err_code_o = ERR_W'(ERR_CTR);
  end
endmodule

// File: rtl/bru_ctr.sv
module bru_ctr #(
  parameter int unsigned CTR_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CTR_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic [CTR_W-1:0] ctr_o,
  output logic [CTR_W-1:0] ctr_dec_o
);
  logic [CTR_W-1:0] ctr_q;

  assign ctr_dec_o = ctr_q - CTR_W'(1);
  assign ctr_o     = ctr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctr_q <= '0;
    else if (load_i) ctr_q <= load_val_i;
    else if (dec_i)  ctr_q <= ctr_dec_o;
  end

  // R2
  ctr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> ctr_q == $past(load_val_i));

  // R4
  ctr_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i) |=> ctr_q == $past(ctr_q) - CTR_W'(1));

  // R12
  ctr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dec_i && !load_i) |=> $stable(ctr_q));
endmodule

// File: rtl/bru_resolve.sv
module bru_resolve
  import bru_pkg::*;
#(
  parameter int unsigned CTR_W = 32
) (
  input  logic             req_i,
  input  logic             cond_i,
  input  bo_fields_t       fld_i,
  input  logic             invalid_i,
  input  logic [CTR_W-1:0] ctr_dec_i,
  output logic             taken_o,
  output logic             hint_o,
  output logic             dec_o
);
  logic ok, cond_ok, ctr_ok, ctr_is_zero;

  assign ok          = req_i & ~invalid_i;
  assign ctr_is_zero = (ctr_dec_i == '0);
  assign cond_ok     = ~fld_i.use_cond | (cond_i == fld_i.cond_sense);
  assign ctr_ok      = ~fld_i.use_ctr | (fld_i.ctr_zero ? ctr_is_zero : ~ctr_is_zero);

  assign taken_o = ok & (fld_i.always_tk | (cond_ok & ctr_ok));
  assign hint_o  = ok & fld_i.hint;
  assign dec_o   = ok & fld_i.use_ctr;
endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
  import bru_pkg::*;
#(
  parameter int unsigned CTR_W   = 32,
  parameter int unsigned ERR_W   = 8,
  parameter int unsigned ERR_Z   = 150,
  parameter int unsigned ERR_CTR = 163
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctr_load_i,
  input  logic [CTR_W-1:0] ctr_load_val_i,
  input  logic             req_i,
  input  logic [4:0]       bo_i,
  input  logic             cond_i,
  input  logic [1:0]       kind_i,
  output logic             taken_o,
  output logic             hint_o,
  output logic             invalid_o,
  output logic [ERR_W-1:0] err_code_o,
  output logic [CTR_W-1:0] ctr_o
);
  bo_fields_t       fld;
  logic             dec_inv;
  logic [ERR_W-1:0] dec_err;
  logic [CTR_W-1:0] ctr_dec;
  logic             dec_en;

  bru_bo_decode #(
    .ERR_W(ERR_W), .ERR_Z(ERR_Z), .ERR_CTR(ERR_CTR)
  ) u_dec (
    .bo_i       (bo_i),
    .kind_i     (kind_i),
    .fld_o      (fld),
    .invalid_o  (dec_inv),
    .err_code_o (dec_err)
  );

  bru_ctr #(.CTR_W(CTR_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ctr_load_i),
    .load_val_i (ctr_load_val_i),
    .dec_i      (dec_en),
    .ctr_o      (ctr_o),
    .ctr_dec_o  (ctr_dec)
  );

  bru_resolve #(.CTR_W(CTR_W)) u_res (
    .req_i     (req_i),
    .cond_i    (cond_i),
    .fld_i     (fld),
    .invalid_i (dec_inv),
    .ctr_dec_i (ctr_dec),
    .taken_o   (taken_o),
    .hint_o    (hint_o),
    .dec_o     (dec_en)
  );

  assign invalid_o  = req_i & dec_inv;
  assign err_code_o = req_i ? dec_err : '0;

  // R10
  inv_not_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> (!taken_o && !hint_o));

  // R10
  inv_ctr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (invalid_o && !ctr_load_i) |=> $stable(ctr_o));

  // R8
  inv_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> (err_code_o == ERR_W'(ERR_Z) || err_code_o == ERR_W'(ERR_CTR)));

  // R8
  valid_no_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !invalid_o |-> err_code_o == '0);

  // R12
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> (!taken_o && !hint_o && !invalid_o));

  // R7
  always_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && bo_i[4] && bo_i[2] && !invalid_o) |-> (taken_o && !hint_o));

  // R3
  cond_only_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !bo_i[4] && bo_i[2] && !ctr_load_i) |=> $stable(ctr_o));
endmodule

// File: tb/branch_resolve_unit_test.sv
`timescale 1ns/1ps
module branch_resolve_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld = 1'b0;
  logic [31:0] ld_val = '0;
  logic        req = 1'b0;
  logic [4:0]  bo = '0;
  logic        cond = 1'b0;
  logic [1:0]  kind = '0;
  logic        taken, hint, inv;
  logic [7:0]  ec;
  logic [31:0] ctr;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [31:0] ref_ctr = '0;
  string       ctr_tag = "R1";

  always #5 clk = ~clk;

  branch_resolve_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .ctr_load_i(ld), .ctr_load_val_i(ld_val),
    .req_i(req), .bo_i(bo), .cond_i(cond), .kind_i(kind),
    .taken_o(taken), .hint_o(hint), .invalid_o(inv), .err_code_o(ec), .ctr_o(ctr)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference of one request
  task automatic model(output bit tk, output bit hn, output bit iv, output int code,
                       output bit dec, output string tag);
    bit zbad = 0, need_cond = 0, need_ctr = 0, alw = 0;
    logic [31:0] nv;
    bit cpass, kpass;
    tag = "R3";
    casez (bo)
      5'b0?1??: begin need_cond = 1; zbad = bo[1]; tag = "R3"; end
      5'b0?0??: begin need_cond = 1; need_ctr = 1; tag = "R4"; end
      5'b1?0??: begin need_ctr = 1; zbad = bo[3]; tag = "R6"; end
      default:  begin alw = 1; zbad = bo[3] | bo[1] | bo[0]; tag = "R7"; end
    endcase
    nv    = ref_ctr - 32'd1;
    kpass = bo[1] ? (nv == 32'd0) : (nv != 32'd0);
    cpass = (cond == bo[3]);
    iv = 0; code = 0;
    if (zbad) begin iv = 1; code = 150; tag = "R8"; end
    else if (kind == 2'd2 && !bo[2]) begin iv = 1; code = 163; tag = "R9"; end
    if (!req) begin
      tk = 0; hn = 0; iv = 0; code = 0; dec = 0; tag = "R12";
    end else if (iv) begin
      tk = 0; hn = 0; dec = 0;
    end else begin
      tk  = alw || ((!need_cond || cpass) && (!need_ctr || kpass));
      hn  = alw ? 1'b0 : bo[0];
      dec = need_ctr;
      if (need_ctr && tag == "R4" && nv == 32'd0) tag = "R5";
    end
  endtask

  task automatic cyc(input bit l, input logic [31:0] lv, input bit r,
                     input logic [4:0] b, input bit c, input logic [1:0] k);
    bit etk, ehn, eiv, edec;
    int ecode;
    string tag;
    @(negedge clk);
    ld = l; ld_val = lv; req = r; bo = b; cond = c; kind = k;
    #4;
    model(etk, ehn, eiv, ecode, edec, tag);
    chk(ctr_tag, "ctr", ctr, ref_ctr);
    chk(tag, "taken", taken, etk);
    chk(eiv ? "R10" : "R11", "hint", hint, ehn);
    chk(tag, "invalid", inv, eiv);
    chk(tag, "err", ec, ecode);
    @(posedge clk);
    if (l) begin ref_ctr = lv; ctr_tag = "R2"; end
    else if (edec) begin ref_ctr = ref_ctr - 32'd1; ctr_tag = "R5"; end
    else ctr_tag = eiv ? "R10" : "R12";
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #4;
    chk("R1", "ctr", ctr, 0);
    chk("R1", "taken", taken, 0);
    chk("R1", "invalid", inv, 0);
    chk("R1", "err", ec, 0);
    @(negedge clk); rst_n = 1'b1;

    cyc(1, 32'd2, 0, 5'b00000, 0, 0);          // R2 load
    cyc(0, 0, 1, 5'b00100, 0, 0);              // R3 cond false -> taken
    cyc(0, 0, 1, 5'b00100, 1, 0);              // R3 not taken
    cyc(0, 0, 1, 5'b01101, 1, 1);              // R3 true, hint R11
    cyc(0, 0, 1, 5'b00000, 0, 0);              // R4 ctr 2->1 nonzero -> taken
    cyc(0, 0, 1, 5'b00010, 0, 0);              // R5 1->0 zero test -> taken
    cyc(0, 0, 1, 5'b10000, 1, 0);              // R5 wrap 0 -> ffffffff, R6
    cyc(1, 32'd1, 1, 5'b10000, 0, 0);          // R2 load beats decrement
    cyc(0, 0, 1, 5'b10010, 0, 2);              // R9 dec on via-counter
    cyc(0, 0, 1, 5'b11000, 0, 2);              // R8 priority over R9
    cyc(0, 0, 1, 5'b10101, 0, 2);              // R8 always with e=1
    cyc(0, 0, 1, 5'b10100, 0, 2);              // R7 always, via counter
    cyc(0, 0, 1, 5'b00110, 1, 0);              // R8 d in cond-only
    cyc(0, 0, 1, 5'b10011, 1, 0);              // R6 zero test + hint
    cyc(0, 0, 0, 5'b10000, 1, 0);              // R12 idle

    for (int i = 0; i < 3000; i++) begin
      int sel = $urandom_range(0, 9);
      logic [31:0] v = (sel < 8) ? 32'($urandom_range(0, 3)) :
                       (sel == 8) ? 32'hFFFF_FFFF : 32'($urandom);
      cyc($urandom_range(0, 9) == 0, v, $urandom_range(0, 9) < 7,
          5'($urandom), 1'($urandom), 2'($urandom));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule